// File: doc/BRIEF.md
# In-band software flow control engine

This block handles character-based flow control for one asynchronous serial channel. Each received character is compared with four programmed control characters: two "pause" characters and two "resume" characters. The comparison works either on a single character or on a two-character sequence. A pause match stops the local transmitter once the character in flight has finished. A resume match lets it continue. Characters consumed as control codes never reach the receive buffer. Every other character is passed on through a one-cycle store strobe.

On the receive-buffer side, the block watches the fill level against two thresholds. It asks the transmit serializer to insert a pause character (or pair) when the buffer fills, and a resume character (or pair) when the buffer drains. A separate special-character mode turns off flow control entirely. In that mode, every received character whose value equals the second pause character raises a status flag, and the character is still stored.

The control characters are loaded through a small write port. The word-length setting narrows every comparison to the low 5, 6, 7 or 8 bits of the character.

Top module: `swfc_engine`

## Requirements
- R1: After a synchronous active-low reset, all of the following are 0: store_valid, tx_halt, status_flag, ins_xoff_req and ins_xon_req. All four control characters also read 0, so ins_first and ins_second are 0.
- R2: Comparisons use only the low bits selected by word_len: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Bit 0 of each control character lines up with bit 0 of rx_char.
- R3: In single mode (fc_en=1, pair_mode=0), a character equal to the first pause character (cfg_sel=2) is dropped. It sets status_flag, and tx_halt rises one cycle after the strobe.
- R4: tx_halt never rises while tx_busy is high. A pending pause takes effect on the first clock edge at which tx_busy is low.
- R5: A character equal to the first resume character (cfg_sel=0) is dropped. It clears tx_halt and status_flag on the clock edge that samples it.
- R6: In pair mode (pair_mode=1), a pause takes effect only for the first pause character followed directly by the second pause character (cfg_sel=3). A resume likewise needs the first resume character followed by the second resume character (cfg_sel=1). Both characters of a matching pair are dropped.
- R7: In pair mode, if a held first character is followed by a non-matching character, the held character is stored on that edge. The new character is then processed one cycle later as a fresh arrival, so the original order is kept.
- R8: A received character that is not consumed as a control code appears unchanged on store_char, with store_valid high for exactly one cycle, one clock edge after rx_valid.
- R9: With fc_en=0 and special_en=1, a character equal to the second pause character is stored and sets status_flag. A flag_clr pulse clears the flag.
- R10: With ins_en=1, the rise of rx_level to xoff_thr or above raises ins_xoff_req once. ins_ack clears the request.
- R11: After a pause insertion, rx_level falling below xon_thr raises ins_xon_req and drops any pending ins_xoff_req. The two requests are never high together.
- R12: ins_first carries the first resume character while ins_xon_req is high, and the first pause character otherwise. ins_second carries the matching second character. ins_two equals pair_mode.
- R13: With fc_en=0, every received character is stored and tx_halt is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for a control character |
| cfg_sel | input | 2 | Character select: 0 first resume, 1 second resume, 2 first pause, 3 second pause |
| cfg_wdata | input | 8 | Control character value |
| word_len | input | 2 | Compare width: 0..3 selects 5..8 bits |
| fc_en | input | 1 | Enable flow-control matching |
| pair_mode | input | 1 | Two-character sequence matching |
| special_en | input | 1 | Special-character flagging (used when fc_en=0) |
| ins_en | input | 1 | Enable threshold-driven insertion requests |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character |
| tx_busy | input | 1 | Transmitter is sending a character |
| flag_clr | input | 1 | Clears status_flag |
| rx_level | input | LVL_W | Receive buffer fill level |
| xoff_thr | input | LVL_W | Level at or above which a pause is requested |
| xon_thr | input | LVL_W | Level below which a resume is requested |
| ins_ack | input | 1 | Serializer has taken the insertion request |
| store_valid | output | 1 | Write strobe toward the receive buffer |
| store_char | output | 8 | Character to store |
| tx_halt | output | 1 | Transmitter must not start a new character |
| status_flag | output | 1 | Pause matched or special character seen |
| ins_xoff_req | output | 1 | Request to send pause character(s) |
| ins_xon_req | output | 1 | Request to send resume character(s) |
| ins_first | output | 8 | First character to insert |
| ins_second | output | 8 | Second character to insert |
| ins_two | output | 1 | Insert both characters |

## Verification
The assertions assume that rx_valid is never high on two consecutive cycles, since on a real serial line characters arrive many clocks apart. This leaves a free cycle for the replayed character of a broken pair. They also assume that flag_clr is not pulsed on the same cycle as a received character. The stimulus places every character strobe on its own negative edge and leaves at least one idle cycle after it. flag_clr is only pulsed with rx_valid low, and thresholds and levels are changed only between edges.

// File: rtl/swfc_pkg.sv
// Shared types and helpers for the software flow control engine.
// Assumes 8-bit characters; narrower word lengths are handled by masking.
package swfc_pkg;
    localparam int CHAR_W = 8;
    localparam int N_CTRL = 4;

    // Index of each control character in the register bank.
    typedef enum logic [1:0] {
        SEL_RESUME_A = 2'd0,
        SEL_RESUME_B = 2'd1,
        SEL_PAUSE_A  = 2'd2,
        SEL_PAUSE_B  = 2'd3
    } ctrl_sel_e;

    // What a held first character of a pair is waiting for.
    typedef enum logic [1:0] {
        HOLD_NONE   = 2'd0,
        HOLD_PAUSE  = 2'd1,
        HOLD_RESUME = 2'd2
    } hold_e;

    // Mask that keeps the low 5..8 bits for word length code 0..3.
    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
        return {CHAR_W{1'b1}} >> (3'd3 - {1'b0, wl});
    endfunction

    // Masked equality of two characters.
    function automatic logic chars_eq(input logic [CHAR_W-1:0] a,
                                      input logic [CHAR_W-1:0] b,
                                      input logic [1:0] wl);
        return ((a ^ b) & len_mask(wl)) == '0;
    endfunction
endpackage

// File: rtl/swfc_char_regs.sv
// Bank of programmable control characters.
// Each entry resets to zero and is loaded by a write strobe with a select.
module swfc_char_regs
    import swfc_pkg::*;
#(
    parameter int N_REGS = N_CTRL,
    localparam int SEL_W = $clog2(N_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SEL_W-1:0]              sel,
    input  logic [CHAR_W-1:0]             wdata,
    output logic [N_REGS-1:0][CHAR_W-1:0] regs_q
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        // Load one control character when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (we && (sel == SEL_W'(g)))
                regs_q[g] <= wdata;
        end
    end
endmodule

// File: rtl/swfc_rx_match.sv
// Receive-side matcher: drops control characters, passes data on, drives
// the transmit halt and the status flag.
// Assumes rx_valid is never high on two back-to-back cycles; the cycle after
// a broken pair is used to replay the second character.
module swfc_rx_match
    import swfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        word_len,
    input  logic              fc_en,
    input  logic              pair_mode,
    input  logic              special_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] resume_a,
    input  logic [CHAR_W-1:0] resume_b,
    input  logic [CHAR_W-1:0] pause_a,
    input  logic [CHAR_W-1:0] pause_b,
    input  logic              tx_busy,
    input  logic              flag_clr,
    output logic              store_valid,
    output logic [CHAR_W-1:0] store_char,
    output logic              tx_halt,
    output logic              status_flag
);
    hold_e             hold_q, hold_n;
    logic [CHAR_W-1:0] held_q, held_n;
    logic              replay_q, replay_n;
    logic [CHAR_W-1:0] replay_c_q, replay_c_n;
    logic              stop_q;

    logic              in_v;
    logic [CHAR_W-1:0] in_c;
    logic              hit_pa, hit_pb, hit_ra, hit_rb;
    logic              do_store, set_stop, do_resume, set_flag;
    logic [CHAR_W-1:0] st_char;

    // Select the character under test: a replayed one or a fresh arrival.
    always_comb begin
        in_v   = rx_valid | replay_q;
        in_c   = replay_q ? replay_c_q : rx_char;
        hit_pa = chars_eq(in_c, pause_a, word_len);
        hit_pb = chars_eq(in_c, pause_b, word_len);
        hit_ra = chars_eq(in_c, resume_a, word_len);
        hit_rb = chars_eq(in_c, resume_b, word_len);
    end

    // Decide store, pause, resume and pair state for the character under test.
    always_comb begin
        do_store   = 1'b0;
        st_char    = in_c;
        set_stop   = 1'b0;
        do_resume  = 1'b0;
        set_flag   = 1'b0;
        hold_n     = hold_q;
        held_n     = held_q;
        replay_n   = 1'b0;
        replay_c_n = replay_c_q;
        if (!(fc_en && pair_mode))
            hold_n = HOLD_NONE;
        if (in_v) begin
            if (!fc_en) begin
                do_store = 1'b1;
                set_flag = special_en && hit_pb;
            end else if (!pair_mode) begin
                if (hit_pa) begin
                    set_stop = 1'b1;
                    set_flag = 1'b1;
                end else if (hit_ra) begin
                    do_resume = 1'b1;
                end else begin
                    do_store = 1'b1;
                end
            end else begin
                case (hold_q)
                    HOLD_PAUSE, HOLD_RESUME: begin
                        hold_n = HOLD_NONE;
                        if (hold_q == HOLD_PAUSE && hit_pb) begin
                            set_stop = 1'b1;
                            set_flag = 1'b1;
                        end else if (hold_q == HOLD_RESUME && hit_rb) begin
                            do_resume = 1'b1;
                        end else begin
                            do_store   = 1'b1;
                            st_char    = held_q;
                            replay_n   = 1'b1;
                            replay_c_n = in_c;
                        end
                    end
                    default: begin
                        if (hit_pa) begin
                            hold_n = HOLD_PAUSE;
                            held_n = in_c;
                        end else if (hit_ra) begin
                            hold_n = HOLD_RESUME;
                            held_n = in_c;
                        end else begin
                            do_store = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // Register pair state, replay slot and the store strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= HOLD_NONE;
            held_q      <= '0;
            replay_q    <= 1'b0;
            replay_c_q  <= '0;
            store_valid <= 1'b0;
            store_char  <= '0;
        end else begin
            hold_q      <= hold_n;
            held_q      <= held_n;
            replay_q    <= replay_n;
            replay_c_q  <= replay_c_n;
            store_valid <= do_store;
            store_char  <= st_char;
        end
    end

    // Track a pending pause and apply it only between transmitted characters.
    always_ff @(posedge clk) begin
        if (!rst_n || !fc_en || do_resume) begin
            stop_q  <= 1'b0;
            tx_halt <= 1'b0;
        end else begin
            if (set_stop)
                stop_q <= 1'b1;
            if (stop_q && !tx_busy)
                tx_halt <= 1'b1;
        end
    end

    // Status flag: set by a pause or special match, cleared by resume or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_flag <= 1'b0;
        else if (set_flag)
            status_flag <= 1'b1;
        else if (do_resume || flag_clr)
            status_flag <= 1'b0;
    end
endmodule

// File: rtl/swfc_insert_ctl.sv
// Threshold watcher that asks the serializer to insert pause or resume codes.
// A newer crossing replaces an older request; an acknowledge clears both.
module swfc_insert_ctl #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] xoff_thr,
    input  logic [LVL_W-1:0] xon_thr,
    input  logic             ins_ack,
    output logic             ins_xoff_req,
    output logic             ins_xon_req
);
    logic remote_off_q;

    // Detect threshold crossings and hold the latest request until taken.
    always_ff @(posedge clk) begin
        if (!rst_n || !ins_en) begin
            remote_off_q <= 1'b0;
            ins_xoff_req <= 1'b0;
            ins_xon_req  <= 1'b0;
        end else if (!remote_off_q && rx_level >= xoff_thr) begin
            remote_off_q <= 1'b1;
            ins_xoff_req <= 1'b1;
            ins_xon_req  <= 1'b0;
        end else if (remote_off_q && rx_level < xon_thr) begin
            remote_off_q <= 1'b0;
            ins_xon_req  <= 1'b1;
            ins_xoff_req <= 1'b0;
        end else if (ins_ack) begin
            ins_xoff_req <= 1'b0;
            ins_xon_req  <= 1'b0;
        end
    end
endmodule

// File: rtl/swfc_engine.sv
// Top of the software flow control engine for one serial channel.
// Ties together the control character bank, the receive matcher and the
// insertion request logic. Assumes the serializer reads ins_first/second
// while a request is high and pulses ins_ack once it has taken it.
module swfc_engine
    import swfc_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [1:0]       word_len,
    input  logic             fc_en,
    input  logic             pair_mode,
    input  logic             special_en,
    input  logic             ins_en,
    input  logic             rx_valid,
    input  logic [7:0]       rx_char,
    input  logic             tx_busy,
    input  logic             flag_clr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] xoff_thr,
    input  logic [LVL_W-1:0] xon_thr,
    input  logic             ins_ack,
    output logic             store_valid,
    output logic [7:0]       store_char,
    output logic             tx_halt,
    output logic             status_flag,
    output logic             ins_xoff_req,
    output logic             ins_xon_req,
    output logic [7:0]       ins_first,
    output logic [7:0]       ins_second,
    output logic             ins_two
);
    logic [N_CTRL-1:0][CHAR_W-1:0] ctrl_q;

    swfc_char_regs #(.N_REGS(N_CTRL)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .regs_q (ctrl_q)
    );

    swfc_rx_match u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_len    (word_len),
        .fc_en       (fc_en),
        .pair_mode   (pair_mode),
        .special_en  (special_en),
        .rx_valid    (rx_valid),
        .rx_char     (rx_char),
        .resume_a    (ctrl_q[SEL_RESUME_A]),
        .resume_b    (ctrl_q[SEL_RESUME_B]),
        .pause_a     (ctrl_q[SEL_PAUSE_A]),
        .pause_b     (ctrl_q[SEL_PAUSE_B]),
        .tx_busy     (tx_busy),
        .flag_clr    (flag_clr),
        .store_valid (store_valid),
        .store_char  (store_char),
        .tx_halt     (tx_halt),
        .status_flag (status_flag)
    );

    swfc_insert_ctl #(.LVL_W(LVL_W)) u_ins (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_en       (ins_en),
        .rx_level     (rx_level),
        .xoff_thr     (xoff_thr),
        .xon_thr      (xon_thr),
        .ins_ack      (ins_ack),
        .ins_xoff_req (ins_xoff_req),
        .ins_xon_req  (ins_xon_req)
    );

    // Present the characters that go with the current insertion request.
    always_comb begin
        ins_first  = ins_xon_req ? ctrl_q[SEL_RESUME_A] : ctrl_q[SEL_PAUSE_A];
        ins_second = ins_xon_req ? ctrl_q[SEL_RESUME_B] : ctrl_q[SEL_PAUSE_B];
        ins_two    = pair_mode;
    end
endmodule

// File: rtl/swfc_engine_checker.sv
// Temporal checks on the flow control engine, attached by bind.
// Assumes rx_valid is never high on consecutive cycles and that flag_clr
// is not pulsed together with rx_valid.
module swfc_engine_checker #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fc_en,
    input logic             rx_valid,
    input logic             tx_busy,
    input logic             flag_clr,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] xoff_thr,
    input logic             store_valid,
    input logic             tx_halt,
    input logic             status_flag,
    input logic             ins_xoff_req,
    input logic             ins_xon_req
);
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!tx_halt && !store_valid && !status_flag
                           && !ins_xoff_req && !ins_xon_req));

    p_halt_waits_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_halt) |-> $past(!tx_busy));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !rx_valid) |=> !status_flag);

    p_xoff_on_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_xoff_req) |-> $past(rx_level >= xoff_thr));

    p_req_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_xoff_req && ins_xon_req));

    p_fc_off_stores_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!fc_en && rx_valid) |=> (store_valid && !tx_halt));
endmodule

bind swfc_engine swfc_engine_checker #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fc_en        (fc_en),
    .rx_valid     (rx_valid),
    .tx_busy      (tx_busy),
    .flag_clr     (flag_clr),
    .rx_level     (rx_level),
    .xoff_thr     (xoff_thr),
    .store_valid  (store_valid),
    .tx_halt      (tx_halt),
    .status_flag  (status_flag),
    .ins_xoff_req (ins_xoff_req),
    .ins_xon_req  (ins_xon_req)
);

// File: tb/swfc_engine_bench.sv
// Self-checking bench for the software flow control engine.
module swfc_engine_bench;
    localparam int LVL_W = 5;

    // Vector: {word_len[1:0], char[7:0], expect_stored, expect_halt_and_flag}
    localparam int NV = 11;
    localparam logic [11:0] VEC [0:NV-1] = '{
        {2'd3, 8'h41, 1'b1, 1'b0},
        {2'd3, 8'h13, 1'b0, 1'b1},
        {2'd3, 8'h11, 1'b0, 1'b0},
        {2'd3, 8'h93, 1'b1, 1'b0},
        {2'd2, 8'h93, 1'b0, 1'b1},
        {2'd2, 8'h91, 1'b0, 1'b0},
        {2'd0, 8'hF3, 1'b0, 1'b1},
        {2'd0, 8'h31, 1'b0, 1'b0},
        {2'd1, 8'h53, 1'b0, 1'b1},
        {2'd3, 8'h55, 1'b1, 1'b1},
        {2'd3, 8'h11, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] word_len = 2'd3;
    logic fc_en = 1'b0, pair_mode = 1'b0, special_en = 1'b0, ins_en = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic tx_busy = 1'b0, flag_clr = 1'b0, ins_ack = 1'b0;
    logic [LVL_W-1:0] rx_level = '0, xoff_thr = 5'd8, xon_thr = 5'd4;
    logic store_valid, tx_halt, status_flag, ins_xoff_req, ins_xon_req, ins_two;
    logic [7:0] store_char, ins_first, ins_second;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    swfc_engine #(.LVL_W(LVL_W)) u_swfc_engine (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Drive one character; returns at the negedge after the sampling edge.
    task automatic send(input logic [7:0] c);
        rx_valid = 1'b1; rx_char = c;
        tick();
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 store_valid", store_valid, 0);
        chk("R1 tx_halt", tx_halt, 0);
        chk("R1 status_flag", status_flag, 0);
        chk("R1 reqs", {ins_xoff_req, ins_xon_req}, 0);
        chk("R1 ctrl chars zero", {ins_first, ins_second}, 0);
        rst_n = 1'b1;
        tick();
        wr(2'd0, 8'h11); wr(2'd1, 8'h91); wr(2'd2, 8'h13); wr(2'd3, 8'h93);
        chk("R12 idle first", ins_first, 8'h13);
        chk("R12 idle second", ins_second, 8'h93);
        chk("R12 two", ins_two, 0);

        // R2 R3 R5 R8 single mode table
        fc_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            word_len = VEC[i][11:10];
            send(VEC[i][9:2]);
            chk("R8 R3 store strobe", store_valid, {31'd0, VEC[i][1]});
            if (VEC[i][1]) chk("R8 store data", store_char, VEC[i][9:2]);
            tick();
            chk("R2 R3 R5 halt", tx_halt, {31'd0, VEC[i][0]});
            chk("R3 R5 flag", status_flag, {31'd0, VEC[i][0]});
        end
        word_len = 2'd3;

        // R4 halt waits for the character in flight
        tx_busy = 1'b1;
        send(8'h13);
        repeat (3) tick();
        chk("R4 halt held off while busy", tx_halt, 0);
        tx_busy = 1'b0;
        tick();
        chk("R4 halt after idle", tx_halt, 1);
        send(8'h11);
        chk("R5 resume clears halt", tx_halt, 0);

        // R6 pair mode
        pair_mode = 1'b1;
        send(8'h13);
        chk("R6 first of pair dropped", store_valid, 0);
        send(8'h93);
        chk("R6 second of pair dropped", store_valid, 0);
        tick();
        chk("R6 pair pause", tx_halt, 1);
        send(8'h11);
        chk("R6 resume first dropped", store_valid, 0);
        chk("R6 half resume keeps halt", tx_halt, 1);
        send(8'h91);
        chk("R6 pair resume", tx_halt, 0);

        // R7 broken pair with plain data
        send(8'h13);
        send(8'h41);
        chk("R7 held stored valid", store_valid, 1);
        chk("R7 held stored char", store_char, 8'h13);
        tick();
        chk("R7 replay stored valid", store_valid, 1);
        chk("R7 replay stored char", store_char, 8'h41);
        tick();
        chk("R7 no halt", tx_halt, 0);
        // R7 broken pair whose second char starts a new pair
        send(8'h11);
        send(8'h13);
        chk("R7 held resume stored", store_char, 8'h11);
        tick();
        chk("R7 replayed start held", store_valid, 0);
        send(8'h93);
        tick();
        chk("R7 replay pair completes", tx_halt, 1);
        send(8'h11); send(8'h91);
        chk("R7 resume", tx_halt, 0);
        pair_mode = 1'b0;

        // R13 flow control off
        send(8'h13);
        fc_en = 1'b0;
        tick();
        chk("R13 halt cleared when off", tx_halt, 0);
        send(8'h13);
        chk("R13 stored valid", store_valid, 1);
        chk("R13 stored char", store_char, 8'h13);
        tick();
        chk("R13 no halt", tx_halt, 0);

        // R9 special character mode
        special_en = 1'b1;
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        send(8'h41);
        chk("R9 no flag on other", status_flag, 0);
        send(8'h93);
        chk("R9 special stored", store_char, 8'h93);
        chk("R9 special flag", status_flag, 1);
        flag_clr = 1'b1; tick(); flag_clr = 1'b0;
        chk("R9 flag cleared", status_flag, 0);
        special_en = 1'b0;

        // R10 R11 R12 insertion requests
        ins_en = 1'b1; pair_mode = 1'b1;
        rx_level = 5'd3; tick(); tick();
        chk("R10 no req below", {ins_xoff_req, ins_xon_req}, 0);
        rx_level = 5'd8; tick();
        chk("R10 xoff req", ins_xoff_req, 1);
        chk("R12 xoff chars", {ins_first, ins_second}, 16'h1393);
        chk("R12 two chars", ins_two, 1);
        rx_level = 5'd9; ins_ack = 1'b1; tick(); ins_ack = 1'b0;
        chk("R10 ack clears", ins_xoff_req, 0);
        tick();
        chk("R10 no repeat", ins_xoff_req, 0);
        rx_level = 5'd5; tick();
        chk("R11 hysteresis", ins_xon_req, 0);
        rx_level = 5'd3; tick();
        chk("R11 xon req", ins_xon_req, 1);
        chk("R12 xon chars", {ins_first, ins_second}, 16'h1191);
        ins_ack = 1'b1; tick(); ins_ack = 1'b0;
        chk("R11 ack", ins_xon_req, 0);
        rx_level = 5'd8; tick();
        chk("R11 new xoff", ins_xoff_req, 1);
        rx_level = 5'd2; tick();
        chk("R11 newest wins xon", ins_xon_req, 1);
        chk("R11 stale xoff dropped", ins_xoff_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule